// File: doc/BRIEF.md
# YUV Output Format Multiplexer

This block takes one luma sample (Y) and two chroma samples (U, V) on every clock and places them on three 8-bit output buses, A, B and C. A 2-bit mode input selects the layout. In the full-rate layout each bus carries its own channel. In the half-rate chroma layout bus A carries luma and bus B alternates U and V from every second sample, with a two-bit marker on bus C. In the quarter-rate chroma layout only every fourth chroma pair is kept, and it is sent two bits per component per clock on the upper half of bus B, with a four-step marker on bus C.

Each output bit comes as a data wire and a drive wire, so the chip-level pads can build the three-state buffers. A bit whose drive is low is treated as high impedance. Each bus has its own enable that releases all of its bits at once. A rising edge on the init input restarts the subsampling phase, so that a downstream receiver can lock to a known chroma group. Samples pass through a fixed pipeline before they reach the buses.

Top module: `yuv_fmt_mux`

## Requirements
- R1: With mode = 2'b01, buses A, B and C carry the Y, U and V sample respectively, and all 8 bits of every bus are driven.
- R2: A sample presented at a rising clock edge reaches the buses just after the sixth rising edge, counting the edge that captures it as the first (parameter LAT = 6). Bus A carries that sample's Y, fully driven, in modes 2'b00, 2'b01 and 2'b10.
- R3: With mode = 2'b10, bus B carries U of a sample with even phase and, on the next clock, V of that same even sample, so the sequence is U0, V0, U2, V2 and so on. All 8 bits of B are driven.
- R4: With mode = 2'b10, bits C[7:6] carry 2'b10 while bus B carries U and 2'b01 while it carries V. C[5:0] are not driven.
- R5: With mode = 2'b00, a sample of phase p (0..3) outputs the chroma of the phase-0 sample of its group. B[7:6] carry U bits [7-2p : 6-2p] and B[5:4] carry V bits [7-2p : 6-2p]. B[3:0] are not driven.
- R6: With mode = 2'b00, C[7:6] carry 2'b10, 2'b00, 2'b00 and 2'b01 for phases 0, 1, 2 and 3. C[5:0] are not driven.
- R7: The sample captured at an edge where init is high and was low at the previous edge gets phase 0. Every other sample gets the previous phase plus one, modulo 4. Holding init high does not restart the phase again. The first sample after reset has phase 0.
- R8: With mode = 2'b11, no bit of any bus is driven.
- R9: When the enable of a bus is low, no bit of that bus is driven, in the same cycle.
- R10: The data value of every bit that is not driven reads 0.
- R11: While reset is asserted, all data and drive outputs are 0.
- R12: The mode is applied at the output stage. A mode change takes effect on the buses after the next rising edge, including for samples already in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Rising edge restarts the subsampling phase |
| mode | input | 2 | Layout select: 00 quarter-rate chroma, 01 full rate, 10 half-rate chroma, 11 all buses released |
| y_in | input | 8 | Luma sample |
| u_in | input | 8 | U chroma sample |
| v_in | input | 8 | V chroma sample |
| oe_a | input | 1 | Enable for bus A |
| oe_b | input | 1 | Enable for bus B |
| oe_c | input | 1 | Enable for bus C |
| a_dat | output | 8 | Bus A data |
| a_drv | output | 8 | Bus A per-bit drive |
| b_dat | output | 8 | Bus B data |
| b_drv | output | 8 | Bus B per-bit drive |
| c_dat | output | 8 | Bus C data |
| c_drv | output | 8 | Bus C per-bit drive |

## Verification
The bench sends init pulses in the middle of a chroma group and holds init high for many clocks. A design that restarted the phase on the level of init, or that kept counting from the old group, would place the wrong bit pairs on B[7:4] and the wrong markers on C[7:6].

On the odd half of the half-rate layout, bus B must carry V of the previous sample and not of the current one; an off-by-one here shows up as a wrong value on B. The bench also changes the mode every few clocks while data is in flight, so a design that sent the mode down the pipeline, or that shared one chroma hold register between layouts, would produce stale chroma.

Random enable toggling, together with the reserved mode, exposes any bit left driven, or any bit that carries non-zero data while it is released.

// File: rtl/yuv_fmt_mux.sv
module yuv_fmt_mux #(
  parameter int W   = 8,
  parameter int LAT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic [1:0]   mode,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] v_in,
  input  logic         oe_a,
  input  logic         oe_b,
  input  logic         oe_c,
  output logic [W-1:0] a_dat,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_dat,
  output logic [W-1:0] b_drv,
  output logic [W-1:0] c_dat,
  output logic [W-1:0] c_drv
);
  localparam int G  = W / 4;
  localparam int D  = LAT - 1;
  localparam int EW = 2 + 3 * W;
  localparam logic [1:0] M411 = 2'b00;
  localparam logic [1:0] M444 = 2'b01;
  localparam logic [1:0] M422 = 2'b10;

  logic          init_q;
  logic [1:0]    ph;
  logic [EW-1:0] pipe [D];
  logic [W-1:0]  hv2, hu4, hv4;
  logic [W-1:0]  ra_dat, ra_drv, rb_dat, rb_drv, rc_dat, rc_drv;
  logic [W-1:0]  na_dat, na_drv, nb_dat, nb_drv, nc_dat, nc_drv;

  wire       rise  = init & ~init_q;
  wire [1:0] ph_nx = rise ? 2'd0 : ph + 2'd1;

  wire [EW-1:0] e    = pipe[D-1];
  wire [1:0]    e_ph = e[EW-1 -: 2];
  wire [W-1:0]  e_y  = e[3*W-1 -: W];
  wire [W-1:0]  e_u  = e[2*W-1 -: W];
  wire [W-1:0]  e_v  = e[W-1:0];

  wire [W-1:0] cu = (e_ph == 2'd0) ? e_u : hu4;
  wire [W-1:0] cv = (e_ph == 2'd0) ? e_v : hv4;

  always_comb begin
    int b;
    b = W - 1 - int'(e_ph) * G;
    na_dat = '0; na_drv = '0;
    nb_dat = '0; nb_drv = '0;
    nc_dat = '0; nc_drv = '0;
    case (mode)
      M444: begin
        na_dat = e_y; na_drv = '1;
        nb_dat = e_u; nb_drv = '1;
        nc_dat = e_v; nc_drv = '1;
      end
      M422: begin
        na_dat = e_y; na_drv = '1;
        nb_dat = e_ph[0] ? hv2 : e_u;
        nb_drv = '1;
        nc_drv[W-1 -: 2] = 2'b11;
        nc_dat[W-1 -: 2] = e_ph[0] ? 2'b01 : 2'b10;
      end
      M411: begin
        na_dat = e_y; na_drv = '1;
        nb_dat[W-1 -: G]   = cu[b -: G];
        nb_dat[W-1-G -: G] = cv[b -: G];
        nb_drv[W-1 -: 2*G] = '1;
        nc_drv[W-1 -: 2] = 2'b11;
        nc_dat[W-1 -: 2] = (e_ph == 2'd0) ? 2'b10 :
                           (e_ph == 2'd3) ? 2'b01 : 2'b00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      ph     <= 2'b11;
      for (int i = 0; i < D; i++) pipe[i] <= '0;
      hv2 <= '0; hu4 <= '0; hv4 <= '0;
      ra_dat <= '0; ra_drv <= '0;
      rb_dat <= '0; rb_drv <= '0;
      rc_dat <= '0; rc_drv <= '0;
    end else begin
      init_q  <= init;
      ph      <= ph_nx;
      pipe[0] <= {ph_nx, y_in, u_in, v_in};
      for (int i = 1; i < D; i++) pipe[i] <= pipe[i-1];
      if (!e_ph[0]) hv2 <= e_v;
      if (e_ph == 2'd0) begin
        hu4 <= e_u;
        hv4 <= e_v;
      end
      ra_dat <= na_dat; ra_drv <= na_drv;
      rb_dat <= nb_dat; rb_drv <= nb_drv;
      rc_dat <= nc_dat; rc_drv <= nc_drv;
    end
  end

  assign a_drv = ra_drv & {W{oe_a}};
  assign b_drv = rb_drv & {W{oe_b}};
  assign c_drv = rc_drv & {W{oe_c}};
  assign a_dat = ra_dat & a_drv;
  assign b_dat = rb_dat & b_drv;
  assign c_dat = rc_dat & c_drv;
endmodule

// File: rtl/yuv_fmt_mux_chk.sv
module yuv_fmt_mux_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         oe_a,
  input logic         oe_b,
  input logic         oe_c,
  input logic [W-1:0] a_dat,
  input logic [W-1:0] a_drv,
  input logic [W-1:0] b_dat,
  input logic [W-1:0] b_drv,
  input logic [W-1:0] c_dat,
  input logic [W-1:0] c_drv
);
  localparam int G = W / 4;
  localparam logic [W-1:0] TOP2  = {2'b11, {(W-2){1'b0}}};
  localparam logic [W-1:0] UPPER = {{(2*G){1'b1}}, {(W-2*G){1'b0}}};

  assert_full_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> (!oe_a || a_drv == '1) && (!oe_b || b_drv == '1) && (!oe_c || c_drv == '1));

  assert_half_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> !oe_c || (c_drv == TOP2 && $countones(c_dat[W-1 -: 2]) == 1));

  assert_quarter_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> !oe_b || b_drv == UPPER);

  assert_quarter_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> !oe_c || (c_drv == TOP2 && c_dat[W-1 -: 2] != 2'b11));

  assert_reserved_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> (a_drv | b_drv | c_drv) == '0);

  assert_bus_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_a |-> a_drv == '0) and (!oe_b |-> b_drv == '0) and (!oe_c |-> c_drv == '0));

  assert_undriven_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_dat & ~a_drv) | (b_dat & ~b_drv) | (c_dat & ~c_drv)) == '0);

  always @(negedge clk)
    if (!rst_n)
      assert_reset_quiet_R11: assert ((a_dat | a_drv | b_dat | b_drv | c_dat | c_drv) == '0);
endmodule

bind yuv_fmt_mux yuv_fmt_mux_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode),
  .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c),
  .a_dat(a_dat), .a_drv(a_drv), .b_dat(b_dat), .b_drv(b_drv),
  .c_dat(c_dat), .c_drv(c_drv)
);

// File: tb/test_yuv_fmt_mux.sv
`timescale 1ns/1ps
module test_yuv_fmt_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [7:0] y_in = '0, u_in = '0, v_in = '0;
  logic oe_a = 1'b1, oe_b = 1'b1, oe_c = 1'b1;
  logic [7:0] a_dat, a_drv, b_dat, b_drv, c_dat, c_drv;

  always #5 clk = ~clk;

  yuv_fmt_mux i_yuv_fmt_mux (
    .clk(clk), .rst_n(rst_n), .init(init), .mode(mode),
    .y_in(y_in), .u_in(u_in), .v_in(v_in),
    .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c),
    .a_dat(a_dat), .a_drv(a_drv), .b_dat(b_dat), .b_drv(b_drv),
    .c_dat(c_dat), .c_drv(c_drv)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] hy [12], hu [12], hv [12];
  int hp [12];
  int bph, since_init, since_mode;
  logic binit_q;
  logic [1:0] mode_q;
  logic [7:0] ea, ead, eb, ebd, ec, ecd;
  string tga, tgb, tgc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) begin hy[i] = 0; hu[i] = 0; hv[i] = 0; hp[i] = 0; end
      bph = 3; binit_q = 0; since_init = 100; since_mode = 100; mode_q = mode;
      ea = 0; ead = 0; eb = 0; ebd = 0; ec = 0; ecd = 0;
      tga = "R11"; tgb = "R11"; tgc = "R11";
    end else begin
      if (init && !binit_q) begin bph = 0; since_init = 0; end
      else begin bph = (bph + 1) % 4; if (since_init < 100) since_init++; end
      binit_q = init;
      if (mode != mode_q) since_mode = 0; else if (since_mode < 100) since_mode++;
      mode_q = mode;
      for (int i = 11; i > 0; i--) begin
        hy[i] = hy[i-1]; hu[i] = hu[i-1]; hv[i] = hv[i-1]; hp[i] = hp[i-1];
      end
      hy[0] = y_in; hu[0] = u_in; hv[0] = v_in; hp[0] = bph;
      begin
        int p;
        logic [7:0] ub, vb;
        p = hp[5];
        ea = 0; ead = 0; eb = 0; ebd = 0; ec = 0; ecd = 0;
        tga = "R2";
        case (mode)
          2'b01: begin
            ea = hy[5]; ead = 8'hFF; eb = hu[5]; ebd = 8'hFF; ec = hv[5]; ecd = 8'hFF;
            tgb = "R1"; tgc = "R1";
          end
          2'b10: begin
            ea = hy[5]; ead = 8'hFF; ebd = 8'hFF; ecd = 8'hC0;
            eb = (p % 2 == 1) ? hv[6] : hu[5];
            ec = (p % 2 == 1) ? 8'h40 : 8'h80;
            tgb = "R3"; tgc = "R4";
          end
          2'b00: begin
            ub = hu[5+p]; vb = hv[5+p];
            ea = hy[5]; ead = 8'hFF;
            eb = {2'((ub >> (6 - 2*p)) & 8'd3), 2'((vb >> (6 - 2*p)) & 8'd3), 4'b0000};
            ebd = 8'hF0; ecd = 8'hC0;
            ec = (p == 0) ? 8'h80 : (p == 3) ? 8'h40 : 8'h00;
            tgb = "R5"; tgc = "R6";
          end
          default: begin tga = "R8"; tgb = "R8"; tgc = "R8"; end
        endcase
        if (since_init < 10 && (mode == 2'b00 || mode == 2'b10)) tgc = "R7";
        if (since_mode == 0) begin tga = "R12"; tgb = "R12"; tgc = "R12"; end
      end
    end
  end

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] ga, gb, gc;
    if (!rst_n) begin
      chk("R11", "reset outputs", a_dat | a_drv | b_dat | b_drv | c_dat | c_drv, 8'h00);
      return;
    end
    ga = oe_a ? ead : 8'h00;
    gb = oe_b ? ebd : 8'h00;
    gc = oe_c ? ecd : 8'h00;
    chk(oe_a ? tga : "R9", "a_drv", a_drv, ga);
    chk(oe_a ? tga : "R9", "a_dat", a_dat, ea & ga);
    chk(oe_b ? tgb : "R9", "b_drv", b_drv, gb);
    chk(oe_b ? tgb : "R9", "b_dat", b_dat, eb & gb);
    chk(oe_c ? tgc : "R9", "c_drv", c_drv, gc);
    chk(oe_c ? tgc : "R9", "c_dat", c_dat, ec & gc);
    chk("R10", "undriven data", (a_dat & ~a_drv) | (b_dat & ~b_drv) | (c_dat & ~c_drv), 8'h00);
  endtask

  task automatic run(int n, bit rnd_oe);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      y_in = 8'($urandom); u_in = 8'($urandom); v_in = 8'($urandom);
      if (rnd_oe) begin
        oe_a = 1'($urandom); oe_b = 1'($urandom); oe_c = 1'($urandom);
      end
    end
  endtask

  task automatic pulse_init(int width);
    init = 1'b1;
    run(width, 0);
    init = 1'b0;
  endtask

  initial begin
    run(3, 0);
    rst_n = 1'b1;
    mode = 2'b01;
    run(40, 0);
    mode = 2'b10;
    run(8, 0);
    pulse_init(1);
    run(25, 0);
    run(1, 0);
    pulse_init(1);
    run(30, 0);
    mode = 2'b00;
    run(9, 0);
    pulse_init(1);
    run(37, 0);
    pulse_init(1);
    run(6, 0);
    pulse_init(11);
    run(30, 0);
    for (int r = 0; r < 15; r++) begin
      mode = 2'(r % 3);
      if (r == 7) pulse_init(2);
      run(7, 0);
    end
    mode = 2'b11;
    run(20, 0);
    for (int r = 0; r < 40; r++) begin
      mode = 2'($urandom);
      if (r % 9 == 4) pulse_init(1);
      run(5, 1);
    end
    oe_a = 1'b1; oe_b = 1'b1; oe_c = 1'b1;
    mode = 2'b00;
    run(20, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule